// File: doc/BRIEF.md
# Shared-Memory Back-Invalidation Directory

This block sits inside a memory device that several hosts share, each host through its own request port. It holds a small data store and, for every line, a holder mask with one bit per host. Reads return data at once and add the reader to the line's holders. A write to a line that other hosts hold is not completed straight away. The device sends a back-invalidation pulse to each of those other holders and parks the write. The write commits only when every targeted host has acknowledged eviction. Reads never pay any coherence cost.

Only one write can be parked at a time. While it waits, other lines stay open to every host except the parked writer, and the parked line is closed to all hosts. Ports that request in the same cycle are served in round-robin order. A write-state machine has two states. In **W_IDLE** no write is parked. The **start** transition W_IDLE→W_WAIT happens when a granted write finds other holders. In **W_WAIT** the block collects acknowledgements. The **commit** transition W_WAIT→W_IDLE happens in the cycle that the last outstanding acknowledgement arrives.

Top module: `bi_directory`

## Requirements
- R1: While reset is held and after it is released, req_ready, rsp_valid, binv_valid and ack_err are all zero until a request is presented.
- R2: A read accepted in cycle t (req_valid and req_ready high for that host at the edge) raises that host's rsp_valid bit for cycle t+1, with the line's stored data on that host's rsp_data slice. The reader is added to the line's holders and no invalidation is sent.
- R3: A write accepted to a line that no other host holds raises rsp_valid for that host in cycle t+1, with the written value echoed on rsp_data. It sends no invalidation.
- R4: A write accepted to a line held by other hosts drives binv_valid for exactly one cycle (t+1). Bit h of binv_valid is set for each holder other than the writer, and the line number is placed on binv_line. The writer's own bit is never set.
- R5: That write's response is withheld until every targeted host has raised its binv_ack bit. It is then delivered one cycle after the edge at which the last acknowledgement is seen, with the written value.
- R6: After a write commits, the writer is the line's only holder, so a later write by another host invalidates only the previous writer.
- R7: While a write is parked, requests to that line from any host, and any request from the parked writer, see req_ready low.
- R8: While a write is parked, reads from other hosts to other lines are accepted and answered as in R2.
- R9: Among simultaneous eligible requesters, the grant goes to the first port at or after the port following the last granted one, counting upward and wrapping at NUM_HOSTS.
- R10: An acknowledgement bit from a host that has no outstanding invalidation sets ack_err, which stays set until reset.
- R11: At most one req_ready bit is high in any cycle.
- R12: When a fresh request is accepted at the same edge as a commit, both the parked writer and the new requester receive their responses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_HOSTS | Request present, one bit per host |
| req_write | input | NUM_HOSTS | 1 = write, 0 = read, per host |
| req_line | input | NUM_HOSTS*LINE_W | Line index per host (host h at bits h*LINE_W) |
| req_wdata | input | NUM_HOSTS*DATA_W | Write data per host |
| req_ready | output | NUM_HOSTS | Request accepted this cycle (one-hot or zero) |
| rsp_valid | output | NUM_HOSTS | Completion pulse per host |
| rsp_data | output | NUM_HOSTS*DATA_W | Read data or echoed write data per host |
| binv_valid | output | NUM_HOSTS | Back-invalidation pulse, one bit per target host |
| binv_line | output | LINE_W | Line being invalidated |
| binv_ack | input | NUM_HOSTS | Eviction acknowledgement per host |
| ack_err | output | 1 | Sticky unexpected-acknowledgement flag |

## Verification
The commit of a parked write and the acceptance of a new request on another line can land on the same clock edge. The bench provokes this by presenting a read from a third host in the same cycle that it raises the last acknowledgement. It then expects both hosts' rsp_valid bits together one cycle later, each with its own data from the bench's model. A second collision comes from arbitration: two hosts request at once. The bench predicts the winner from the rotating pointer it tracks, and the loser is expected to be granted in the following cycle.

// File: rtl/bi_pkg.sv
package bi_pkg;
    typedef enum logic {
        W_IDLE = 1'b0,
        W_WAIT = 1'b1
    } wstate_e;
endpackage

// File: rtl/bi_rr_arb.sv
module bi_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr;
    logic          found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int off = 0; off < N; off++) begin
            int c;
            c = (int'(ptr) + off) % N;
            if (!found && req[c]) begin
                found   = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = PW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (found)
            ptr <= PW'((int'(gnt_idx) + 1) % N);
    end
endmodule

// File: rtl/bi_dir_store.sv
module bi_dir_store #(
    parameter int H  = 4,
    parameter int L  = 16,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_en,
    input  logic                 a_write,
    input  logic [$clog2(L)-1:0] a_line,
    input  logic [$clog2(H)-1:0] a_host,
    input  logic [DW-1:0]        a_data,
    input  logic                 b_en,
    input  logic [$clog2(L)-1:0] b_line,
    input  logic [$clog2(H)-1:0] b_host,
    input  logic [DW-1:0]        b_data,
    output logic [DW-1:0]        rd_data,
    output logic [L*H-1:0]       sh_flat
);
    logic [DW-1:0] mem [L];
    logic [H-1:0]  sh  [L];

    assign rd_data = mem[a_line];

    generate
        for (genvar i = 0; i < L; i++) begin : g_line
            assign sh_flat[i*H +: H] = sh[i];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i] <= '0;
                    sh[i]  <= '0;
                end else if (b_en && int'(b_line) == i) begin
                    mem[i] <= b_data;
                    sh[i]  <= H'(1) << b_host;
                end else if (a_en && int'(a_line) == i) begin
                    if (a_write) begin
                        mem[i] <= a_data;
                        sh[i]  <= H'(1) << a_host;
                    end else begin
                        sh[i]  <= sh[i] | (H'(1) << a_host);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bi_directory.sv
module bi_directory #(
    parameter int NUM_HOSTS = 4,
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 16,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int HOST_W   = $clog2(NUM_HOSTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_HOSTS-1:0]        req_valid,
    input  logic [NUM_HOSTS-1:0]        req_write,
    input  logic [NUM_HOSTS*LINE_W-1:0] req_line,
    input  logic [NUM_HOSTS*DATA_W-1:0] req_wdata,
    output logic [NUM_HOSTS-1:0]        req_ready,
    output logic [NUM_HOSTS-1:0]        rsp_valid,
    output logic [NUM_HOSTS*DATA_W-1:0] rsp_data,
    output logic [NUM_HOSTS-1:0]        binv_valid,
    output logic [LINE_W-1:0]           binv_line,
    input  logic [NUM_HOSTS-1:0]        binv_ack,
    output logic                        ack_err
);
    import bi_pkg::*;
    localparam int H = NUM_HOSTS;

    wstate_e         state, state_nx;
    logic [LINE_W-1:0] p_line;
    logic [DATA_W-1:0] p_data;
    logic [HOST_W-1:0] p_host;
    logic [H-1:0]      remain, remain_nx, stray;

    logic [H-1:0]      elig, gnt;
    logic [HOST_W-1:0] g_idx;
    logic [LINE_W-1:0] g_line;
    logic              g_write;
    logic [DATA_W-1:0] g_data, rd_data;
    logic [H-1:0]      g_others;
    logic [NUM_LINES*H-1:0] sh_flat;
    logic              start, a_en, commit;
    logic [DATA_W-1:0] rsp_q [H];

    // eligibility: parked line and parked writer are closed, one parked write at most
    always_comb begin
        for (int h = 0; h < H; h++) begin
            logic [LINE_W-1:0] lh;
            logic [H-1:0]      othr;
            lh      = req_line[h*LINE_W +: LINE_W];
            othr    = sh_flat[int'(lh)*H +: H] & ~(H'(1) << h);
            elig[h] = req_valid[h];
            if (state == W_WAIT) begin
                if (lh == p_line || HOST_W'(h) == p_host) elig[h] = 1'b0;
                if (req_write[h] && othr != '0)           elig[h] = 1'b0;
            end
        end
    end

    bi_rr_arb #(.N(H)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .gnt     (gnt),
        .gnt_idx (g_idx)
    );

    assign req_ready = gnt;
    assign g_line    = req_line[int'(g_idx)*LINE_W +: LINE_W];
    assign g_write   = req_write[g_idx];
    assign g_data    = req_wdata[int'(g_idx)*DATA_W +: DATA_W];
    assign g_others  = sh_flat[int'(g_line)*H +: H] & ~(H'(1) << g_idx);
    assign start     = (|gnt) && g_write && (g_others != '0);
    assign a_en      = (|gnt) && !start;
    assign remain_nx = remain & ~binv_ack;
    assign stray     = binv_ack & ~remain;
    assign commit    = (state == W_WAIT) && (remain_nx == '0);

    bi_dir_store #(.H(H), .L(NUM_LINES), .DW(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (a_en),
        .a_write (g_write),
        .a_line  (g_line),
        .a_host  (g_idx),
        .a_data  (g_data),
        .b_en    (commit),
        .b_line  (p_line),
        .b_host  (p_host),
        .b_data  (p_data),
        .rd_data (rd_data),
        .sh_flat (sh_flat)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            W_IDLE: if (start)  state_nx = W_WAIT;
            W_WAIT: if (commit) state_nx = W_IDLE;
        endcase
    end

    // state register and parked-write context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= W_IDLE;
            p_line <= '0;
            p_data <= '0;
            p_host <= '0;
            remain <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                p_line <= g_line;
                p_data <= g_data;
                p_host <= g_idx;
                remain <= g_others;
            end else if (state == W_WAIT) begin
                remain <= remain_nx;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= '0;
            binv_valid <= '0;
            binv_line  <= '0;
            ack_err    <= 1'b0;
            for (int h = 0; h < H; h++) rsp_q[h] <= '0;
        end else begin
            rsp_valid  <= '0;
            binv_valid <= '0;
            if (a_en) begin
                rsp_valid[g_idx] <= 1'b1;
                rsp_q[g_idx]     <= g_write ? g_data : rd_data;
            end
            if (start) begin
                binv_valid <= g_others;
                binv_line  <= g_line;
            end
            if (commit) begin
                rsp_valid[p_host] <= 1'b1;
                rsp_q[p_host]     <= p_data;
            end
            if (stray != '0) ack_err <= 1'b1;
        end
    end

    generate
        for (genvar h = 0; h < H; h++) begin : g_rsp
            assign rsp_data[h*DATA_W +: DATA_W] = rsp_q[h];
        end
    endgenerate
endmodule

// File: rtl/bi_dir_chk.sv
module bi_dir_chk #(
    parameter int H = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [H-1:0] req_ready,
    input logic [H-1:0] binv_valid,
    input logic [H-1:0] binv_ack,
    input logic         ack_err
);
    // R11
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |=> ack_err);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_err) |-> ($past(binv_ack) != '0));

    // R4
    binv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (binv_valid != '0) |=> (binv_valid == '0));
endmodule

bind bi_directory bi_dir_chk #(.H(NUM_HOSTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .binv_valid (binv_valid),
    .binv_ack   (binv_ack),
    .ack_err    (ack_err)
);

// File: tb/bi_directory_tb.sv
module bi_directory_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H  = 4;
    localparam int L  = 16;
    localparam int DW = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [H-1:0]    req_valid = '0, req_write = '0, binv_ack = '0;
    logic [H*LW-1:0] req_line = '0;
    logic [H*DW-1:0] req_wdata = '0;
    logic [H-1:0]    req_ready, rsp_valid, binv_valid;
    logic [H*DW-1:0] rsp_data;
    logic [LW-1:0]   binv_line;
    logic            ack_err;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] m_mem [L];
    logic [H-1:0]  m_sh  [L];

    always #(CLK_PERIOD/2) clk = ~clk;

    bi_directory #(.NUM_HOSTS(H), .NUM_LINES(L), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .binv_valid(binv_valid),
        .binv_line(binv_line), .binv_ack(binv_ack), .ack_err(ack_err)
    );

    function automatic logic [H-1:0] expect_inval(int h, int line);
        return m_sh[line] & ~(H'(1) << h);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic drive(input int h, input bit wr, input int line, input logic [DW-1:0] d);
        req_valid[h] = 1'b1;
        req_write[h] = wr;
        req_line[h*LW +: LW] = LW'(line);
        req_wdata[h*DW +: DW] = d;
    endtask

    task automatic do_op(input int h, input bit wr, input int line,
                         input logic [DW-1:0] d, input int ackdly, input string tag);
        logic [H-1:0] eb;
        eb = wr ? expect_inval(h, line) : '0;
        @(negedge clk);
        drive(h, wr, line, d);
        #1 chk(req_ready == (H'(1) << h), "R11", req_ready, H'(1) << h);
        @(negedge clk);
        req_valid[h] = 1'b0;
        chk(binv_valid == eb, tag, binv_valid, eb);
        if (eb == '0) begin
            chk(rsp_valid[h], wr ? "R3" : "R2", rsp_valid, H'(1) << h);
            if (wr) chk(rsp_data[h*DW +: DW] == d, "R3", rsp_data[h*DW +: DW], d);
            else    chk(rsp_data[h*DW +: DW] == m_mem[line], "R2", rsp_data[h*DW +: DW], m_mem[line]);
        end else begin
            chk(binv_line == LW'(line), "R4", binv_line, line);
            chk(!rsp_valid[h], "R5", rsp_valid, 0);
            for (int k = 0; k < ackdly; k++) begin
                @(negedge clk);
                chk(!rsp_valid[h], "R5", rsp_valid, 0);
            end
            binv_ack = eb;
            @(negedge clk);
            binv_ack = '0;
            chk(rsp_valid[h], "R5", rsp_valid, H'(1) << h);
            chk(rsp_data[h*DW +: DW] == d, "R5", rsp_data[h*DW +: DW], d);
        end
        if (wr) begin m_mem[line] = d; m_sh[line] = H'(1) << h; end
        else    m_sh[line] = m_sh[line] | (H'(1) << h);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_sim();
    end

    initial begin
        logic [H-1:0] eb;
        void'($urandom(32'd77));
        for (int i = 0; i < L; i++) begin m_mem[i] = '0; m_sh[i] = '0; end
        repeat (3) @(negedge clk);
        chk(rsp_valid == '0 && binv_valid == '0 && req_ready == '0 && !ack_err, "R1", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == '0 && binv_valid == '0 && !ack_err, "R1", binv_valid, 0);

        // R2 / R3 / R4 / R5 / R6 directed
        do_op(0, 1'b1, 3, 16'h1234, 0, "R3");
        do_op(1, 1'b0, 3, 16'h0, 0, "R2");
        do_op(2, 1'b0, 3, 16'h0, 0, "R2");
        do_op(0, 1'b0, 3, 16'h0, 0, "R2");
        do_op(0, 1'b1, 3, 16'h5678, 2, "R4 writer excluded");
        do_op(1, 1'b1, 3, 16'h9ABC, 1, "R6 only previous writer");

        // R7 / R8 / R12: parked write, blocked and open ports, same-edge commit
        do_op(1, 1'b0, 5, 16'h0, 0, "R2");
        @(negedge clk);
        eb = expect_inval(0, 5);
        drive(0, 1'b1, 5, 16'hA5A5);
        @(negedge clk);
        req_valid = '0;
        chk(binv_valid == eb, "R4", binv_valid, eb);
        drive(3, 1'b0, 5, 16'h0);
        drive(2, 1'b0, 7, 16'h0);
        drive(0, 1'b0, 6, 16'h0);
        #1 chk(!req_ready[3], "R7 parked line", req_ready, 4'b0100);
        chk(!req_ready[0], "R7 parked writer", req_ready, 4'b0100);
        chk(req_ready[2], "R8", req_ready, 4'b0100);
        @(negedge clk);
        req_valid = '0;
        chk(rsp_valid == 4'b0100, "R8", rsp_valid, 4'b0100);
        chk(rsp_data[2*DW +: DW] == m_mem[7], "R8", rsp_data[2*DW +: DW], m_mem[7]);
        m_sh[7] = m_sh[7] | 4'b0100;
        drive(2, 1'b0, 8, 16'h0);
        binv_ack = eb;
        #1 chk(req_ready[2], "R12", req_ready, 4'b0100);
        @(negedge clk);
        req_valid = '0;
        binv_ack  = '0;
        chk(rsp_valid == 4'b0101, "R12", rsp_valid, 4'b0101);
        chk(rsp_data[0 +: DW] == 16'hA5A5, "R12", rsp_data[0 +: DW], 16'hA5A5);
        chk(rsp_data[2*DW +: DW] == m_mem[8], "R12", rsp_data[2*DW +: DW], m_mem[8]);
        m_mem[5] = 16'hA5A5; m_sh[5] = 4'b0001;
        m_sh[8] = m_sh[8] | 4'b0100;
        do_op(3, 1'b0, 5, 16'h0, 0, "R2");

        // R9 round robin: last grant host 1, so host 2 wins over host 0
        do_op(1, 1'b0, 9, 16'h0, 0, "R2");
        @(negedge clk);
        drive(0, 1'b0, 10, 16'h0);
        drive(2, 1'b0, 11, 16'h0);
        #1 chk(req_ready == 4'b0100, "R9", req_ready, 4'b0100);
        @(negedge clk);
        req_valid[2] = 1'b0;
        #1 chk(req_ready == 4'b0001, "R9", req_ready, 4'b0001);
        @(negedge clk);
        req_valid = '0;
        m_sh[10] = m_sh[10] | 4'b0001;
        m_sh[11] = m_sh[11] | 4'b0100;

        // constrained random single-host traffic against the model
        for (int n = 0; n < 400; n++) begin
            int h, line, wr, dly;
            h    = int'($urandom % H);
            line = int'($urandom % 6);
            wr   = int'($urandom % 3 == 0);
            dly  = int'($urandom % 4);
            do_op(h, wr[0], line, DW'($urandom), dly, wr[0] ? "R4" : "R2");
        end

        // R10: stray acknowledgement
        chk(!ack_err, "R10 clean", ack_err, 0);
        @(negedge clk);
        binv_ack = 4'b0010;
        @(negedge clk);
        binv_ack = '0;
        chk(ack_err, "R10", ack_err, 1);
        repeat (3) @(negedge clk);
        chk(ack_err, "R10 sticky", ack_err, 1);
        finish_sim();
    end
endmodule